// File: doc/BRIEF.md
# Interrupt Cause Aggregation Controller

This block collects single-cycle event pulses from three interrupt groups: transmit, receive and miscellaneous. Each group owns a bank of latched cause bits with a per-bit choice of how a bit is acknowledged: either by writing a one to it, or simply by reading the cause register. Each bank also keeps a source mask, which software changes only through separate set and clear registers and can read back through its own register.

On top of the three banks sits a three-bit summary register. Each summary bit reports whether its group holds any cause bit that is not masked. Reading the summary register acknowledges it. A software mask on the summary decides which groups may raise the single registered host interrupt line. Every register sits behind one synchronous read/write port. Read data appears one cycle after the read strobe.

Address map: `addr_i[4:3]` selects the region (0 transmit bank, 1 receive bank, 2 miscellaneous bank, 3 summary). `addr_i[2:0]` selects the register. In a bank: 0 cause, 1 clear-mode, 2 mask set, 3 mask clear, 4 mask value. In the summary region: 0 summary, 1 summary mask.

Top module: `irqagg_ctrl`

## Requirements
- R1: After reset, every cause register reads 0, every clear-mode register reads 0, every mask value register reads all ones, the summary reads 0, the summary mask reads all ones and `irq_o` is 0.
- R2: An event pulse on a source bit sets that cause bit at the next clock edge. The bit stays set until it is acknowledged. If an event and an acknowledge reach the same bit in the same cycle, the bit stays set.
- R3: A write to the cause register clears each bit that has a 1 in the write data and a 0 in its clear-mode bit. Bits with a 0 in the write data are unchanged. Bits in clear-on-read mode ignore the write.
- R4: A read of the cause register returns its value from before the read, and then clears only the bits whose clear-mode bit is 1. Write-1-to-clear bits are not changed by reads.
- R5: The clear-mode register (register 1) can be written and read back. A 1 in a bit selects clear-on-read for that bit, and a 0 selects write-1-to-clear.
- R6: A write to mask set (register 2) sets the mask bits that are 1 in the data. A write to mask clear (register 3) clears the mask bits that are 1 in the data. Zero data bits leave mask bits unchanged. Mask value (register 4) returns the current mask.
- R7: Summary bit 0 reports receive, bit 1 reports transmit and bit 2 reports miscellaneous. A summary bit is set one cycle after its group holds an unmasked cause bit. A masked cause bit never sets it.
- R8: A read of the summary register returns the latched bits and then clears them. A bit whose group still holds an unmasked cause bit stays set.
- R9: The summary mask register can be written and read back. `irq_o` rises one cycle after a summary bit is set while the matching summary mask bit is 0. `irq_o` stays 0 while the mask blocks every group.
- R10: Reads of unmapped registers, and of the mask set and mask clear registers, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_tx_i | input | CAUSE_W | Transmit group event pulses |
| evt_rx_i | input | CAUSE_W | Receive group event pulses |
| evt_misc_i | input | CAUSE_W | Miscellaneous group event pulses |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register address, region in [4:3] and register in [2:0] |
| wdata_i | input | CAUSE_W | Write data |
| rdata_o | output | CAUSE_W | Registered read data, valid one cycle after rd_en_i |
| irq_o | output | 1 | Registered host interrupt |

## Verification
A wrong cause bit appears in the cause read data one cycle after the next read strobe. It appears at the summary one cycle after the bit is unmasked, and at `irq_o` one cycle after that. A stuck acknowledge shows up as a second read returning the same value where it should return zero, or the reverse. A wrong clear-mode bit shows up as a read that clears a bit it should not, or a write that fails to clear it. A corrupted mask shows up at once in the mask value readback, and it also shows as a summary bit that sets or stays clear when it should not. A wrong summary bit order shows up as the wrong summary bit rising for a group.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int NGRP   = 3;
  localparam int ADDR_W = 5;
  localparam int REG_W  = 3;

  localparam logic [1:0] REGION_TX   = 2'd0;
  localparam logic [1:0] REGION_RX   = 2'd1;
  localparam logic [1:0] REGION_MISC = 2'd2;
  localparam logic [1:0] REGION_SUM  = 2'd3;

  typedef enum logic [REG_W-1:0] {
    REG_CAUSE = 3'd0,
    REG_MODE  = 3'd1,
    REG_MSET  = 3'd2,
    REG_MCLR  = 3'd3,
    REG_MVAL  = 3'd4
  } bank_reg_e;

  localparam logic [REG_W-1:0] SREG_STAT = 3'd0;
  localparam logic [REG_W-1:0] SREG_MASK = 3'd1;

  // summary bit order: receive, transmit, miscellaneous
  localparam int SUM_RX   = 0;
  localparam int SUM_TX   = 1;
  localparam int SUM_MISC = 2;
endpackage

// File: rtl/irqagg_bank.sv
module irqagg_bank
  import irqagg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [W-1:0]     evt_i,
  input  logic             sel_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rd_val_o,
  output logic [W-1:0]     cause_o,
  output logic [W-1:0]     mask_o,
  output logic             live_o
);
  logic [W-1:0] cause_q, mode_q, mask_q, clr_v;
  logic hit_w, hit_r;

  assign hit_w = sel_i & wr_en_i;
  assign hit_r = sel_i & rd_en_i;

  always_comb begin
    clr_v = '0;
    if (hit_w && reg_i == REG_CAUSE) clr_v = clr_v | (wdata_i & ~mode_q);
    if (hit_r && reg_i == REG_CAUSE) clr_v = clr_v | mode_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cause_q <= '0;
      mode_q  <= '0;
      mask_q  <= '1;
    end else begin
      // new events win over a same-cycle acknowledge
      cause_q <= (cause_q & ~clr_v) | evt_i;
      if (hit_w) begin
        case (reg_i)
          REG_MODE: mode_q <= wdata_i;
          REG_MSET: mask_q <= mask_q | wdata_i;
          REG_MCLR: mask_q <= mask_q & ~wdata_i;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_i)
      REG_CAUSE: rd_val_o = cause_q;
      REG_MODE:  rd_val_o = mode_q;
      REG_MVAL:  rd_val_o = mask_q;
      default:   rd_val_o = '0;
    endcase
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign live_o  = |(cause_q & ~mask_q);
endmodule

// File: rtl/irqagg_summary.sv
module irqagg_summary
  import irqagg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [NGRP-1:0]  live_i,
  input  logic             sel_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rd_val_o,
  output logic [NGRP-1:0]  sum_o,
  output logic [W-1:0]     swmask_o,
  output logic             irq_o
);
  logic [NGRP-1:0] sum_q, rd_clr;
  logic [W-1:0]    swmask_q;
  logic            irq_q;

  assign rd_clr = (sel_i && rd_en_i && reg_i == SREG_STAT) ? '1 : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sum_q    <= '0;
      swmask_q <= '1;
      irq_q    <= 1'b0;
    end else begin
      sum_q <= (sum_q & ~rd_clr) | live_i;
      if (sel_i && wr_en_i && reg_i == SREG_MASK) swmask_q <= wdata_i;
      irq_q <= |(sum_q & ~swmask_q[NGRP-1:0]);
    end
  end

  always_comb begin
    case (reg_i)
      SREG_STAT: rd_val_o = {{(W-NGRP){1'b0}}, sum_q};
      SREG_MASK: rd_val_o = swmask_q;
      default:   rd_val_o = '0;
    endcase
  end

  assign sum_o    = sum_q;
  assign swmask_o = swmask_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter int CAUSE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [CAUSE_W-1:0] evt_tx_i,
  input  logic [CAUSE_W-1:0] evt_rx_i,
  input  logic [CAUSE_W-1:0] evt_misc_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CAUSE_W-1:0] wdata_i,
  output logic [CAUSE_W-1:0] rdata_o,
  output logic               irq_o
);
  logic [1:0]                     region;
  logic [REG_W-1:0]               reg_sel;
  logic [NGRP-1:0][CAUSE_W-1:0]   evt_vec, bank_rd, cause_vec, mask_vec;
  logic [NGRP-1:0]                live_grp, live_sum, sum_q;
  logic [CAUSE_W-1:0]             sum_rd, swmask, rd_mux, rdata_q;

  assign region  = addr_i[ADDR_W-1:REG_W];
  assign reg_sel = addr_i[REG_W-1:0];

  assign evt_vec[REGION_TX]   = evt_tx_i;
  assign evt_vec[REGION_RX]   = evt_rx_i;
  assign evt_vec[REGION_MISC] = evt_misc_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_bank
    irqagg_bank #(.W(CAUSE_W)) u_bank (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .evt_i   (evt_vec[g]),
      .sel_i   (region == 2'(g)),
      .wr_en_i (wr_en_i),
      .rd_en_i (rd_en_i),
      .reg_i   (reg_sel),
      .wdata_i (wdata_i),
      .rd_val_o(bank_rd[g]),
      .cause_o (cause_vec[g]),
      .mask_o  (mask_vec[g]),
      .live_o  (live_grp[g])
    );
  end

  assign live_sum[SUM_RX]   = live_grp[REGION_RX];
  assign live_sum[SUM_TX]   = live_grp[REGION_TX];
  assign live_sum[SUM_MISC] = live_grp[REGION_MISC];

  irqagg_summary #(.W(CAUSE_W)) u_sum (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .live_i  (live_sum),
    .sel_i   (region == REGION_SUM),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .reg_i   (reg_sel),
    .wdata_i (wdata_i),
    .rd_val_o(sum_rd),
    .sum_o   (sum_q),
    .swmask_o(swmask),
    .irq_o   (irq_o)
  );

  always_comb begin
    case (region)
      REGION_TX:   rd_mux = bank_rd[REGION_TX];
      REGION_RX:   rd_mux = bank_rd[REGION_RX];
      REGION_MISC: rd_mux = bank_rd[REGION_MISC];
      default:     rd_mux = sum_rd;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_q <= '0;
    else       rdata_q <= rd_en_i ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irqagg_ctrl_chk.sv
module irqagg_ctrl_chk
  import irqagg_pkg::*;
#(
  parameter int CAUSE_W = 8
) (
  input logic                           clk_i,
  input logic                           rst_i,
  input logic                           wr_en_i,
  input logic [NGRP-1:0][CAUSE_W-1:0]   evt_vec,
  input logic [NGRP-1:0][CAUSE_W-1:0]   cause_vec,
  input logic [NGRP-1:0][CAUSE_W-1:0]   mask_vec,
  input logic [NGRP-1:0]                live_sum,
  input logic [NGRP-1:0]                sum_q,
  input logic [NGRP-1:0]                swmask_lo,
  input logic                           irq_o
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (|evt_vec[g]) |=> ((cause_vec[g] & $past(evt_vec[g])) == $past(evt_vec[g])));
    assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (evt_vec[g] == '0) |=> ((cause_vec[g] & ~$past(cause_vec[g])) == '0));
  end

  assert_mask_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_en_i |=> $stable(mask_vec));

  for (genvar k = 0; k < NGRP; k++) begin : g_sum
    assert_sum_sets_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      live_sum[k] |=> sum_q[k]);
  end

  assert_irq_blocked_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (&swmask_lo) |=> !irq_o);
endmodule

bind irqagg_ctrl irqagg_ctrl_chk #(.CAUSE_W(CAUSE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .wr_en_i  (wr_en_i),
  .evt_vec  (evt_vec),
  .cause_vec(cause_vec),
  .mask_vec (mask_vec),
  .live_sum (live_sum),
  .sum_q    (sum_q),
  .swmask_lo(swmask[irqagg_pkg::NGRP-1:0]),
  .irq_o    (irq_o)
);

// File: tb/irqagg_ctrl_test.sv
module irqagg_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] evt_tx = '0, evt_rx = '0, evt_misc = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irqagg_ctrl #(.CAUSE_W(W)) uut (
    .clk_i(clk), .rst_i(rst),
    .evt_tx_i(evt_tx), .evt_rx_i(evt_rx), .evt_misc_i(evt_misc),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int grp, input int rg, input logic [W-1:0] d);
    addr = 5'((grp << 3) | rg); wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int grp, input int rg, output logic [W-1:0] d);
    addr = 5'((grp << 3) | rg); rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int grp, input logic [W-1:0] v);
    if (grp == 0) evt_tx = v; else if (grp == 1) evt_rx = v; else evt_misc = v;
    tick();
    evt_tx = '0; evt_rx = '0; evt_misc = '0;
  endtask

  function automatic int sum_bit(input int grp);
    // summary order: bit0 receive, bit1 transmit, bit2 misc
    if (grp == 0) return 1;
    if (grp == 1) return 0;
    return 2;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    for (int g = 0; g < 3; g++) begin
      rd(g, 0, v); chk("R1 cause", v, '0);
      rd(g, 1, v); chk("R1 mode", v, '0);
      rd(g, 4, v); chk("R1 mask", v, '1);
    end
    rd(3, 0, v); chk("R1 summary", v, '0);
    rd(3, 1, v); chk("R1 summary mask", v, '1);
    chk("R1 irq", W'(irq), '0);

    // R2/R3/R4 sweep every bit of every group in write-1-to-clear mode
    for (int g = 0; g < 3; g++) begin
      for (int b = 0; b < W; b++) begin
        pulse(g, W'(1) << b);
        rd(g, 0, v); chk("R2 set", v, W'(1) << b);
        rd(g, 0, v); chk("R4 read keeps w1c bit", v, W'(1) << b);
        wr(g, 0, ~(W'(1) << b));
        rd(g, 0, v); chk("R3 zero data bit kept", v, W'(1) << b);
        wr(g, 0, W'(1) << b);
        rd(g, 0, v); chk("R3 w1c clears", v, '0);
      end
    end

    // R5/R3/R4 clear-on-read, full and mixed
    for (int g = 0; g < 3; g++) begin
      wr(g, 1, '1);
      rd(g, 1, v); chk("R5 mode readback", v, '1);
      pulse(g, 8'h5A);
      wr(g, 0, '1);
      rd(g, 0, v); chk("R3 write ignored in cor", v, 8'h5A);
      rd(g, 0, v); chk("R4 cor cleared", v, '0);
      wr(g, 1, 8'h0F);
      rd(g, 1, v); chk("R5 mode mixed", v, 8'h0F);
      pulse(g, '1);
      rd(g, 0, v); chk("R4 mixed first read", v, '1);
      rd(g, 0, v); chk("R4 only cor bits cleared", v, 8'hF0);
      wr(g, 1, '0);
      wr(g, 0, '1);
      rd(g, 0, v); chk("R3 cleanup", v, '0);
    end

    // R2 set wins over same-cycle acknowledge (w1c and cor)
    pulse(0, 8'h01);
    evt_tx = 8'h01; addr = 5'd0; wdata = 8'h01; wr_en = 1'b1;
    tick();
    evt_tx = '0; wr_en = 1'b0;
    rd(0, 0, v); chk("R2 event beats w1c", v, 8'h01);
    wr(0, 0, '1);
    wr(1, 1, '1);
    pulse(1, 8'h80);
    evt_rx = 8'h80; addr = 5'd8; rd_en = 1'b1;
    tick();
    evt_rx = '0; rd_en = 1'b0;
    chk("R4 read returns pre-clear", rdata, 8'h80);
    rd(1, 0, v); chk("R2 event beats cor read", v, 8'h80);
    rd(1, 0, v); chk("R4 then cleared", v, '0);
    wr(1, 1, '0);

    // R6 mask set/clear
    for (int g = 0; g < 3; g++) begin
      wr(g, 3, 8'h0F);
      rd(g, 4, v); chk("R6 mask clear", v, 8'hF0);
      wr(g, 2, 8'h03);
      rd(g, 4, v); chk("R6 mask set", v, 8'hF3);
      wr(g, 3, 8'h00);
      rd(g, 4, v); chk("R6 zero data no change", v, 8'hF3);
      wr(g, 2, '1);
      rd(g, 4, v); chk("R6 all masked", v, '1);
    end

    // R7/R8/R9 summary and interrupt per group
    for (int g = 0; g < 3; g++) begin
      wr(g, 3, 8'h04);
      pulse(g, 8'h08);
      tick(); tick();
      rd(3, 0, v); chk("R7 masked cause ignored", v, '0);
      pulse(g, 8'h04);
      tick();
      rd(3, 0, v); chk("R7 summary bit", v, W'(1) << sum_bit(g));
      rd(3, 0, v); chk("R8 stays while live", v, W'(1) << sum_bit(g));
      chk("R9 blocked irq", W'(irq), '0);
      wr(3, 1, 8'hF8);
      rd(3, 1, v); chk("R9 mask readback", v, 8'hF8);
      tick();
      chk("R9 irq raised", W'(irq), 8'h01);
      wr(g, 0, '1);
      rd(3, 0, v); chk("R8 read returns latched", v, W'(1) << sum_bit(g));
      rd(3, 0, v); chk("R8 cleared after read", v, '0);
      tick();
      chk("R9 irq dropped", W'(irq), '0);
      wr(3, 1, '1);
      wr(g, 2, '1);
    end

    // R10 unmapped and write-only registers
    rd(0, 2, v); chk("R10 mask set reads zero", v, '0);
    rd(1, 3, v); chk("R10 mask clear reads zero", v, '0);
    rd(2, 6, v); chk("R10 unmapped bank reg", v, '0);
    rd(3, 5, v); chk("R10 unmapped summary reg", v, '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule